// File: doc/BRIEF.md
# True-Color Pixel Bus Unpacker

This block takes words from a 16- or 32-bit pixel bus and turns them into a stream of decoded colour pixels. A load strobe captures the whole bus word in one cycle. The word is then split into one or two pixels, which leave on successive pixel-step strobes. The low 16-bit group always goes first.

Each pixel is unpacked into 8-bit red, green and blue values and an 8-bit overlay value. The packing depends on a 6-bit mode code. The number of pixels per load is held in a separate ratio register, which a mode change does not touch. An overlay mask register is ANDed onto the overlay output, so writing it to zero suppresses the overlay.

The model is fully synchronous to one clock. The load and pixel clocks are represented by the enables `busLoad` and `pixStep`.

Top module: `truecolor_unpacker`

## Requirements
- R1: After reset, `pixValid`, `red`, `green`, `blue` and `overlay` are all 0. Reset also sets the mode code to 000000 (an unsupported code), the ratio register to one pixel per load and the overlay mask to FFh.
- R2: A configuration write (`cfgWrEn`=1) updates one register, chosen by `cfgAddr`:
  - address 0 writes the mode from `cfgWrData[5:0]`, and bits 7:6 are ignored;
  - address 1 writes the ratio;
  - address 2 writes the overlay mask;
  - address 3 changes nothing.
- R3: On a cycle with `busLoad`=1, all 32 bits of `busData` are captured at once, and any `pixStep` in that cycle is ignored. After that, each `pixStep` emits the next pending pixel. `pixValid` is 1 for exactly the cycle after that step. Steps made after the pending pixels run out produce no `pixValid`.
- R4: When `cfgWrData[1:0]` of the last ratio write was 2, a load yields two pixels: bits 15:0 first, then bits 31:16. Any other value yields one pixel, taken from bits 15:0. In the 24-bit modes both pixels decode the full 32-bit word. Writing the mode never changes the ratio.
- R5: Modes 001000 and 001010 use the 15-bit group layout:
  - overlay = {7'b0, bit 15};
  - red from bits 14:10;
  - green from bits 9:5;
  - blue from bits 4:0.
- R6: Modes 001001 and 001011 use the 16-bit group layout:
  - red from bits 15:11;
  - green from bits 10:5;
  - blue from bits 4:0;
  - the overlay is 0.
- R7: Mode 001110 decodes the whole word as follows:
  - overlay = bits 31:24;
  - red = bits 23:16;
  - green = bits 15:8;
  - blue = bits 7:0.
- R8: Mode 001101 decodes the whole word as follows:
  - blue = bits 31:24;
  - green = bits 23:16;
  - red = bits 15:8;
  - overlay = bits 7:0.
- R9: A 5-bit component x widens to {x, x[4:2]}, and a 6-bit component y widens to {y, y[5:4]}.
- R10: The overlay output is the decoded overlay ANDed with the mask register. A mask of 00h therefore always gives an overlay of 0.
- R11: Any other mode code gives 0 for red, green, blue and overlay, while `pixValid` still pulses as in R3.
- R12: The colour and overlay outputs keep their values between pixels. A new load restarts the sequence at the low group, even if a pixel from the previous load was still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 mode, 1 ratio, 2 overlay mask |
| cfgWrData | input | 8 | Configuration write data |
| busLoad | input | 1 | Load-clock enable: captures `busData` |
| busData | input | 32 | Pixel bus word |
| pixStep | input | 1 | Pixel-clock enable: emits the next pixel |
| pixValid | output | 1 | One-cycle strobe marking a new pixel |
| red | output | 8 | Decoded red |
| green | output | 8 | Decoded green |
| blue | output | 8 | Decoded blue |
| overlay | output | 8 | Decoded overlay after the mask |

## Verification
The bench builds the block with the package defaults: a 32-bit bus, 16-bit groups and 8-bit channels. These values make every group position and layout from R4 to R8 reachable, including the upper group in the single-load 16-bit modes.

The pixel clock is modelled as the ratio setting multiplied by the load rate: the bench issues as many pixel steps per load as the ratio allows, plus one extra step. This puts the over-step, mid-sequence reload and mask-zero corners within reach in a few hundred cycles.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int BUS_W  = 32;
  localparam int GRP_W  = BUS_W / 2;
  localparam int CH_W   = 8;
  localparam int MODE_W = 6;
  localparam int CFG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [MODE_W-1:0] MODE_15_NARROW = 6'b001000;
  localparam logic [MODE_W-1:0] MODE_16_NARROW = 6'b001001;
  localparam logic [MODE_W-1:0] MODE_15_WIDE   = 6'b001010;
  localparam logic [MODE_W-1:0] MODE_16_WIDE   = 6'b001011;
  localparam logic [MODE_W-1:0] MODE_24_OVLHI  = 6'b001110;
  localparam logic [MODE_W-1:0] MODE_24_OVLLO  = 6'b001101;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RATIO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd2;

  typedef struct packed {
    logic latch;
    logic emit;
    logic upper;
  } tcuStrobe_t;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
    logic [CH_W-1:0] ovl;
  } tcuPixel_t;
endpackage

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              busLoad,
  input  logic              pixStep,
  output tcuStrobe_t        strb,
  output logic [MODE_W-1:0] modeVal,
  output logic [CH_W-1:0]   maskVal
);
  localparam logic [1:0] RATIO_DUAL = 2'd2;

  logic       dualReg;
  logic [1:0] remain;
  logic       upperReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeVal <= '0;
      dualReg <= 1'b0;
      maskVal <= '1;
    end else if (cfgWrEn) begin
      unique case (cfgAddr)
        ADDR_MODE:  modeVal <= cfgWrData[MODE_W-1:0];
        ADDR_RATIO: dualReg <= (cfgWrData[1:0] == RATIO_DUAL);
        ADDR_MASK:  maskVal <= cfgWrData[CH_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.latch = busLoad;
    strb.emit  = pixStep && !busLoad && (remain != 2'd0);
    strb.upper = upperReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain   <= 2'd0;
      upperReg <= 1'b0;
    end else if (busLoad) begin
      remain   <= dualReg ? 2'd2 : 2'd1;
      upperReg <= 1'b0;
    end else if (strb.emit) begin
      remain   <= remain - 2'd1;
      upperReg <= 1'b1;
    end
  end
endmodule

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tcuStrobe_t        strb,
  input  logic [MODE_W-1:0] modeVal,
  input  logic [CH_W-1:0]   maskVal,
  input  logic [BUS_W-1:0]  busData,
  output logic              pixValid,
  output tcuPixel_t         pixOut
);
  logic [BUS_W-1:0] holdWord;
  tcuPixel_t        decoded;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] x);
    return {x, x[5:4]};
  endfunction

  always_comb begin
    logic [GRP_W-1:0] grp;
    grp     = strb.upper ? holdWord[BUS_W-1:GRP_W] : holdWord[GRP_W-1:0];
    decoded = '0;
    case (modeVal)
      MODE_15_NARROW, MODE_15_WIDE: begin
        decoded.ovl   = {{(CH_W-1){1'b0}}, grp[15]};
        decoded.red   = widen5(grp[14:10]);
        decoded.green = widen5(grp[9:5]);
        decoded.blue  = widen5(grp[4:0]);
      end
      MODE_16_NARROW, MODE_16_WIDE: begin
        decoded.red   = widen5(grp[15:11]);
        decoded.green = widen6(grp[10:5]);
        decoded.blue  = widen5(grp[4:0]);
      end
      MODE_24_OVLHI: begin
        decoded.ovl   = holdWord[31:24];
        decoded.red   = holdWord[23:16];
        decoded.green = holdWord[15:8];
        decoded.blue  = holdWord[7:0];
      end
      MODE_24_OVLLO: begin
        decoded.blue  = holdWord[31:24];
        decoded.green = holdWord[23:16];
        decoded.red   = holdWord[15:8];
        decoded.ovl   = holdWord[7:0];
      end
      default: decoded = '0;
    endcase
    decoded.ovl = decoded.ovl & maskVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdWord <= '0;
    else if (strb.latch) holdWord <= busData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixOut   <= '0;
    end else begin
      pixValid <= strb.emit;
      if (strb.emit) pixOut <= decoded;
    end
  end
endmodule

// File: rtl/truecolor_unpacker.sv
module truecolor_unpacker
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              busLoad,
  input  logic [BUS_W-1:0]  busData,
  input  logic              pixStep,
  output logic              pixValid,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   green,
  output logic [CH_W-1:0]   blue,
  output logic [CH_W-1:0]   overlay
);
  tcuStrobe_t        strb;
  tcuPixel_t         pixOut;
  logic [MODE_W-1:0] modeVal;
  logic [CH_W-1:0]   maskVal;

  tcu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .busLoad(busLoad), .pixStep(pixStep),
    .strb(strb), .modeVal(modeVal), .maskVal(maskVal)
  );

  tcu_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeVal(modeVal),
    .maskVal(maskVal), .busData(busData), .pixValid(pixValid),
    .pixOut(pixOut)
  );

  assign red     = pixOut.red;
  assign green   = pixOut.green;
  assign blue    = pixOut.blue;
  assign overlay = pixOut.ovl;
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker
  import tcu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busLoad,
  input logic              pixStep,
  input logic              pixValid,
  input logic [CH_W-1:0]   red,
  input logic [CH_W-1:0]   overlay,
  input logic [MODE_W-1:0] modeVal,
  input logic [CH_W-1:0]   maskVal
);
  logic [1:0] validCnt;

  always_ff @(posedge clk) begin
    if (!rstN) validCnt <= 2'd0;
    else if (busLoad) validCnt <= 2'd0;
    else if (pixValid && validCnt != 2'd3) validCnt <= validCnt + 2'd1;
  end

  // R3
  valid_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> ($past(pixStep) && !$past(busLoad)));

  // R4
  max_two_per_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (validCnt < 2'd2));

  // R10
  mask_zero_ovl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(maskVal) == '0) |-> (overlay == '0));

  // R6
  no_ovl_565_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && ($past(modeVal) == MODE_16_NARROW || $past(modeVal) == MODE_16_WIDE))
      |-> (overlay == '0));

  // R12
  hold_colour_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> ($stable(red) && $stable(overlay)));
endmodule

bind truecolor_unpacker tcu_checker u_chk (
  .clk(clk), .rstN(rstN), .busLoad(busLoad), .pixStep(pixStep),
  .pixValid(pixValid), .red(red), .overlay(overlay),
  .modeVal(modeVal), .maskVal(maskVal)
);

// File: tb/truecolor_unpacker_test.sv
module truecolor_unpacker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        busLoad = 1'b0;
  logic [31:0] busData = '0;
  logic        pixStep = 1'b0;
  logic        pixValid;
  logic [7:0]  red, green, blue, overlay;

  int checks = 0;
  int errors = 0;
  logic [5:0] shMode = '0;
  logic       shDual = 1'b0;
  logic [7:0] shMask = 8'hFF;

  always #5 clk = ~clk;

  truecolor_unpacker uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .busLoad(busLoad), .busData(busData),
    .pixStep(pixStep), .pixValid(pixValid), .red(red), .green(green),
    .blue(blue), .overlay(overlay)
  );

  function automatic logic [7:0] ex5(input logic [4:0] x);
    return (8'(x) << 3) | (8'(x) >> 2);
  endfunction

  function automatic logic [7:0] ex6(input logic [5:0] x);
    return (8'(x) << 2) | (8'(x) >> 4);
  endfunction

  // expected {red, green, blue, overlay}
  function automatic logic [31:0] refPix(input logic [5:0] m, input logic [31:0] w,
                                         input logic up, input logic [7:0] mk);
    logic [15:0] g;
    logic [7:0] r, gr, b, o;
    g = up ? w[31:16] : w[15:0];
    r = 0; gr = 0; b = 0; o = 0;
    if (m == 6'h08 || m == 6'h0A) begin
      o = {7'd0, g[15]}; r = ex5(g[14:10]); gr = ex5(g[9:5]); b = ex5(g[4:0]);
    end else if (m == 6'h09 || m == 6'h0B) begin
      r = ex5(g[15:11]); gr = ex6(g[10:5]); b = ex5(g[4:0]);
    end else if (m == 6'h0E) begin
      o = w[31:24]; r = w[23:16]; gr = w[15:8]; b = w[7:0];
    end else if (m == 6'h0D) begin
      b = w[31:24]; gr = w[23:16]; r = w[15:8]; o = w[7:0];
    end
    return {r, gr, b, o & mk};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == 2'd0) shMode = d[5:0];
    else if (a == 2'd1) shDual = (d[1:0] == 2'd2);
    else if (a == 2'd2) shMask = d;
  endtask

  task automatic loadWord(input logic [31:0] w, input logic alsoStep);
    @(negedge clk);
    busLoad = 1'b1; busData = w; pixStep = alsoStep;
    @(negedge clk);
    busLoad = 1'b0; pixStep = 1'b0;
  endtask

  task automatic stepExpect(input string tag, input logic [31:0] w, input logic up);
    @(negedge clk);
    pixStep = 1'b1;
    @(negedge clk);
    pixStep = 1'b0;
    check({tag, " valid"}, 64'(pixValid), 64'd1);
    check({tag, " pixel"}, 64'({red, green, blue, overlay}), 64'(refPix(shMode, w, up, shMask)));
  endtask

  task automatic stepNone(input string tag);
    @(negedge clk);
    pixStep = 1'b1;
    @(negedge clk);
    pixStep = 1'b0;
    check({tag, " no valid"}, 64'(pixValid), 64'd0);
  endtask

  task automatic runWord(input string tag, input logic [31:0] w);
    loadWord(w, 1'b0);
    stepExpect(tag, w, 1'b0);
    if (shDual) stepExpect(tag, w, 1'b1);
    stepNone(tag);
  endtask

  task automatic testReset();
    // R1 reset values
    check("R1 outputs", 64'({pixValid, red, green, blue, overlay}), 64'd0);
    loadWord(32'hFFFF_FFFF, 1'b0);
    stepExpect("R1 mode0 gives zeros R11", 32'hFFFF_FFFF, 1'b0);
    stepNone("R1 ratio one");
  endtask

  task automatic testNarrow();
    cfgWrite(2'd0, 8'h08);
    runWord("R5 15bit narrow", 32'h1234_ABCD);
    runWord("R5 R9 15bit ones", 32'h0000_FFFF);
    cfgWrite(2'd0, 8'h09);
    runWord("R6 R9 16bit narrow", $urandom);
    runWord("R6 16bit full", 32'h0000_FFFF);
  endtask

  task automatic testWide();
    cfgWrite(2'd1, 8'h02);
    cfgWrite(2'd0, 8'h0A);
    runWord("R4 R5 15bit wide", 32'h8421_7BDE);
    cfgWrite(2'd0, 8'h0B);
    runWord("R4 R6 16bit wide", $urandom);
  endtask

  task automatic test24();
    cfgWrite(2'd1, 8'h01);
    cfgWrite(2'd0, 8'h0E);
    runWord("R7 24bit ovl high", 32'hA5C3_9617);
    cfgWrite(2'd0, 8'h0D);
    runWord("R8 24bit ovl low", 32'h1E2D_3C4B);
    cfgWrite(2'd1, 8'h02);
    runWord("R4 24bit dual full word", 32'h7788_99AA);
  endtask

  task automatic testMask();
    cfgWrite(2'd1, 8'h01);
    cfgWrite(2'd0, 8'h0E);
    cfgWrite(2'd2, 8'h0F);
    runWord("R10 mask and", 32'hF5C3_9617);
    cfgWrite(2'd2, 8'h00);
    runWord("R10 mask zero", 32'hFFC3_9617);
    cfgWrite(2'd0, 8'h08);
    runWord("R10 mask zero 15bit", 32'hFFFF_FFFF);
    cfgWrite(2'd2, 8'hFF);
  endtask

  task automatic testCfgDecode();
    cfgWrite(2'd0, 8'hC9);
    check("R2 bits 7:6 ignored", 64'(shMode), 64'h09);
    runWord("R2 mode via C9", 32'h0000_F81F);
    cfgWrite(2'd3, 8'h0E);
    shMode = 6'h09;
    runWord("R2 addr3 no effect", 32'h0000_07E0);
    cfgWrite(2'd1, 8'h02);
    cfgWrite(2'd0, 8'h0E);
    runWord("R4 ratio kept on mode write", 32'h0102_0304);
    cfgWrite(2'd0, 8'h3F);
    runWord("R11 unsupported", 32'hFFFF_FFFF);
  endtask

  task automatic testSequence();
    cfgWrite(2'd1, 8'h02);
    cfgWrite(2'd0, 8'h09);
    runWord("R4 upper group narrow mode", 32'hF800_001F);
    runWord("R4 no lockup after", 32'h07E0_F800);
    // R3: step in load cycle ignored
    loadWord(32'h1111_2222, 1'b1);
    check("R3 step during load ignored", 64'(pixValid), 64'd0);
    stepExpect("R3 first after load", 32'h1111_2222, 1'b0);
    // R12: hold between pixels
    @(negedge clk);
    check("R12 hold", 64'({pixValid, red, green, blue, overlay}),
          64'({1'b0, refPix(shMode, 32'h1111_2222, 1'b0, shMask)}));
    // R12: reload with a pixel pending restarts low
    loadWord(32'hABCD_1357, 1'b0);
    stepExpect("R12 restart low", 32'hABCD_1357, 1'b0);
    stepExpect("R12 then upper", 32'hABCD_1357, 1'b1);
    stepNone("R3 exhausted");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNarrow();
    testWide();
    test24();
    testMask();
    testCfgDecode();
    testSequence();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule